// File: doc/BRIEF.md
# Decoupled Register Access Proxy

This block lets a host reach registers in a power domain that may be asleep or changing frequency, without the host first waking that domain. The host sees two 32-bit registers: a data word and a command word. To start a transfer, the host writes the command word once. That write carries a start flag, a direction bit, a domain selector and a 23-bit target offset. The proxy waits until the selected domain reports ready. It then moves exactly one dword over a back-end request/acknowledge bus and clears the start flag when the transfer is over.

For a store, the host loads the data word first and then writes the command word. For a load, the host writes the command word, polls until the start flag reads 0, and then reads the data word. A 64-bit value is fetched as two loads to consecutive offsets, low dword first. If a transfer gets no acknowledge within a programmable number of cycles, it is abandoned and a sticky error flag is raised.

Top module: `regproxy`

## Requirements
- R1: After reset, the data word reads 0, the command word reads 0 and `bk_req` is low.
- R2: The data word is at host offset 0xF00 and the command word at 0xF04. Every other offset reads 0. Command word layout: bit 31 is the start flag, bit 30 is the error flag, bits 29:28 are the domain, bit 24 is the direction (0 = store, 1 = load) and bits 22:0 are the offset. Bits 27:25 and bit 23 always read 0.
- R3: A store command drives `bk_req` with `bk_we`=1, `bk_addr` set to the offset, `bk_wdata` set to the data word and `bk_dom` set to the domain. The start flag reads 0 from the cycle after the clock edge that samples `bk_ack`.
- R4: A load command drives `bk_we`=0. The `bk_rdata` value present with `bk_ack` becomes the data word, and the start flag clears on the same edge.
- R5: Domains 0, 1 and 2 wait for `dom_rdy[0]`, `dom_rdy[1]` and `dom_rdy[2]` respectively. Domain 3 waits until all three bits are high. No request is raised before that.
- R6: While the start flag is set, host writes to either register have no effect.
- R7: If no acknowledge arrives, the edge that is `tmo_limit`+1 cycles after the start clears the start flag and sets the error flag. The data word is left unchanged.
- R8: A command-word write with bit 30 set clears the error flag. A write with bit 30 clear leaves the error flag as it was.
- R9: A command-word write with bit 31 clear stores the fields but raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_wr | input | 1 | Host write strobe |
| hst_addr | input | AW | Host byte offset |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Register read data for `hst_addr` |
| tmo_limit | input | TW | Timeout in cycles |
| dom_rdy | input | 3 | Per-domain ready (bit 0 blitter, 1 render, 2 media) |
| bk_req | output | 1 | Back-end request |
| bk_we | output | 1 | Back-end direction, 1 = store |
| bk_dom | output | 2 | Target domain |
| bk_addr | output | 23 | Target register offset |
| bk_wdata | output | 32 | Store data |
| bk_ack | input | 1 | Back-end completion |
| bk_rdata | input | 32 | Load data, valid with `bk_ack` |

## Verification
The stimulus runs stores and loads to different domains and offsets. A store and a load to the same bus show whether the direction bit and the data path are wired correctly. A back-to-back pair of loads checks that nothing carries over from one command to the next. Holding one ready bit low exposes each domain's ready gating, and holding a different bit low for domain 3 confirms that it needs all three. A back end that never answers tests the timeout window to the exact cycle. Writes made while a command is pending show that the command cannot be corrupted.

// File: rtl/regproxy.sv
module regproxy #(
  parameter int AW = 12,
  parameter int TW = 16,
  parameter logic [AW-1:0] DATA_OFS = 'hF00,
  parameter logic [AW-1:0] CMD_OFS  = 'hF04
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hst_wr,
  input  logic [AW-1:0] hst_addr,
  input  logic [31:0]   hst_wdata,
  output logic [31:0]   hst_rdata,
  input  logic [TW-1:0] tmo_limit,
  input  logic [2:0]    dom_rdy,
  output logic          bk_req,
  output logic          bk_we,
  output logic [1:0]    bk_dom,
  output logic [22:0]   bk_addr,
  output logic [31:0]   bk_wdata,
  input  logic          bk_ack,
  input  logic [31:0]   bk_rdata
);

  logic          start_q, err_q, ld_q;
  logic [1:0]    dom_q;
  logic [22:0]   ofs_q;
  logic [31:0]   word_q;
  logic [TW-1:0] cnt_q;

  wire dom_ok  = (dom_q == 2'd3) ? &dom_rdy : dom_rdy[dom_q];
  wire fin     = bk_req & bk_ack;
  wire expire  = start_q & ~fin & (cnt_q == tmo_limit);
  wire wr_word = hst_wr & (hst_addr == DATA_OFS) & ~start_q;
  wire wr_cmd  = hst_wr & (hst_addr == CMD_OFS) & ~start_q;

  assign bk_req   = start_q & dom_ok;
  assign bk_we    = ~ld_q;
  assign bk_dom   = dom_q;
  assign bk_addr  = ofs_q;
  assign bk_wdata = word_q;

  always_comb begin
    if (hst_addr == DATA_OFS)
      hst_rdata = word_q;
    else if (hst_addr == CMD_OFS)
      hst_rdata = {start_q, err_q, dom_q, 3'b000, ld_q, 1'b0, ofs_q};
    else
      hst_rdata = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      err_q   <= 1'b0;
      ld_q    <= 1'b0;
      dom_q   <= '0;
      ofs_q   <= '0;
      cnt_q   <= '0;
    end else if (wr_cmd) begin
      start_q <= hst_wdata[31];
      dom_q   <= hst_wdata[29:28];
      ld_q    <= hst_wdata[24];
      ofs_q   <= hst_wdata[22:0];
      cnt_q   <= '0;
      if (hst_wdata[30]) err_q <= 1'b0;
    end else if (start_q) begin
      if (fin) begin
        start_q <= 1'b0;
      end else if (expire) begin
        start_q <= 1'b0;
        err_q   <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      word_q <= '0;
    else if (wr_word)
      word_q <= hst_wdata;
    else if (fin && ld_q)
      word_q <= bk_rdata;
  end

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> (!start_q || ($stable(bk_addr) && $stable(bk_dom) && $stable(bk_we)))); // R6
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && !(bk_req && bk_ack && !bk_we)) |=> $stable(bk_wdata)); // R6
  AST_ACK_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bk_req && bk_ack) |=> !start_q); // R3
  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (bk_req && bk_ack && !bk_we) |=> (word_q == $past(bk_rdata))); // R4
  AST_ERR_ON_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> ($fell(start_q) && !$past(bk_ack))); // R7

endmodule

// File: tb/test_regproxy.sv
module test_regproxy;
  localparam int AW = 12;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hst_wr = 1'b0;
  logic [AW-1:0] hst_addr = '0;
  logic [31:0]   hst_wdata = '0;
  logic [31:0]   hst_rdata;
  logic [TW-1:0] tmo_limit = 16'd40;
  logic [2:0]    dom_rdy = 3'b111;
  logic          bk_req, bk_we, bk_ack = 1'b0;
  logic [1:0]    bk_dom;
  logic [22:0]   bk_addr;
  logic [31:0]   bk_wdata, bk_rdata = '0;

  int total = 0, bad = 0;
  bit ack_en = 1'b1;
  logic [57:0] expq[$];

  always #4 clk = ~clk;

  regproxy #(.AW(AW), .TW(TW)) i_regproxy (
    .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .tmo_limit(tmo_limit),
    .dom_rdy(dom_rdy), .bk_req(bk_req), .bk_we(bk_we), .bk_dom(bk_dom),
    .bk_addr(bk_addr), .bk_wdata(bk_wdata), .bk_ack(bk_ack), .bk_rdata(bk_rdata));

  function automatic logic [31:0] model(input logic [22:0] a);
    return 32'hA500_0000 ^ {9'd0, a};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compares each back-end transfer with the queued expectation
  always @(negedge clk) begin
    bk_ack = 1'b0;
    if (bk_req && ack_en) begin
      if (expq.size() == 0) begin
        check(1'b0, "R3/R4 unexpected transfer", {9'd0, bk_addr}, 32'h0);
      end else begin
        logic [57:0] e;
        e = expq.pop_front();
        check(bk_we == e[57], "R3/R4 direction", {31'd0, bk_we}, {31'd0, e[57]});
        check(bk_dom == e[56:55], "R3 domain", {30'd0, bk_dom}, {30'd0, e[56:55]});
        check(bk_addr == e[54:32], "R3 offset", {9'd0, bk_addr}, {9'd0, e[54:32]});
        if (e[57]) check(bk_wdata == e[31:0], "R3 store data", bk_wdata, e[31:0]);
      end
      bk_rdata = model(bk_addr);
      bk_ack = 1'b1;
    end
  end

  task automatic hwrite(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_wr = 1'b0;
  endtask

  task automatic hread(input logic [AW-1:0] a, output logic [31:0] d);
    hst_addr = a;
    #1;
    d = hst_rdata;
  endtask

  task automatic push(input bit we, input logic [1:0] dm, input logic [22:0] a, input logic [31:0] d);
    expq.push_back({we, dm, a, d});
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] c;
    for (int i = 0; i < 60; i++) begin
      hread(12'hF04, c);
      if (!c[31]) return;
      @(negedge clk);
    end
    check(1'b0, req, c, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 32'h0, 32'h1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    hread(12'hF00, v); check(v == 0, "R1 data word", v, 0);
    hread(12'hF04, v); check(v == 0, "R1 command word", v, 0);
    check(bk_req == 0, "R1 bk_req", {31'd0, bk_req}, 0);

    // R9 / R2: fields only, reserved bits dropped
    hwrite(12'hF04, 32'h1FB4_5678);
    repeat (3) @(negedge clk);
    hread(12'hF04, v); check(v == 32'h1134_5678, "R2 R9 layout", v, 32'h1134_5678);
    check(bk_req == 0, "R9 no request", {31'd0, bk_req}, 0);
    hwrite(12'hF00, 32'h0000_0777);
    hread(12'hF08, v); check(v == 0, "R2 unmapped", v, 0);

    // R3 store
    hwrite(12'hF00, 32'hDEAD_BEEF);
    push(1'b1, 2'd2, 23'h1000, 32'hDEAD_BEEF);
    hwrite(12'hF04, 32'hA000_1000);
    wait_idle("R3 completion");
    hread(12'hF04, v); check(v == 32'h2000_1000, "R3 start cleared", v, 32'h2000_1000);

    // R4 load
    push(1'b0, 2'd0, 23'h40, 0);
    hwrite(12'hF04, 32'h8100_0040);
    wait_idle("R4 completion");
    hread(12'hF00, v); check(v == model(23'h40), "R4 load data", v, model(23'h40));

    // R4 64-bit as two loads
    push(1'b0, 2'd1, 23'h100, 0);
    hwrite(12'hF04, 32'h9100_0100);
    wait_idle("R4 low dword");
    hread(12'hF00, v); check(v == model(23'h100), "R4 low dword", v, model(23'h100));
    push(1'b0, 2'd1, 23'h104, 0);
    hwrite(12'hF04, 32'h9100_0104);
    wait_idle("R4 high dword");
    hread(12'hF00, v); check(v == model(23'h104), "R4 high dword", v, model(23'h104));

    // R5 single-domain wait and R6 busy writes ignored
    hwrite(12'hF00, 32'h0BAD_F00D);
    dom_rdy = 3'b011;
    push(1'b1, 2'd2, 23'h22, 32'h0BAD_F00D);
    hwrite(12'hF04, 32'hA000_0022);
    hwrite(12'hF00, 32'h1234_5678);
    hwrite(12'hF04, 32'h0000_0000);
    repeat (3) @(negedge clk);
    check(bk_req == 0, "R5 media not ready", {31'd0, bk_req}, 0);
    hread(12'hF04, v); check(v == 32'hA000_0022, "R6 command kept", v, 32'hA000_0022);
    hread(12'hF00, v); check(v == 32'h0BAD_F00D, "R6 data kept", v, 32'h0BAD_F00D);
    dom_rdy = 3'b111;
    wait_idle("R5 release");

    // R5 all-domain wait
    dom_rdy = 3'b110;
    push(1'b1, 2'd3, 23'h7F_FFFF, 32'h0BAD_F00D);
    hwrite(12'hF04, 32'hB07F_FFFF);
    repeat (4) @(negedge clk);
    check(bk_req == 0, "R5 all-domain wait", {31'd0, bk_req}, 0);
    dom_rdy = 3'b111;
    wait_idle("R5 all release");

    // R7 timeout after tmo_limit+1 cycles
    tmo_limit = 16'd10;
    ack_en = 1'b0;
    hwrite(12'hF00, 32'h0000_0055);
    hwrite(12'hF04, 32'h8100_0300);
    repeat (10) @(negedge clk);
    hread(12'hF04, v); check(v[31] == 1, "R7 still pending", v, 32'h8100_0300);
    @(negedge clk);
    hread(12'hF04, v); check(v == 32'h4100_0300, "R7 aborted with error", v, 32'h4100_0300);
    hread(12'hF00, v); check(v == 32'h55, "R7 data unchanged", v, 32'h55);
    ack_en = 1'b1;

    // R8 write-one-to-clear
    hwrite(12'hF04, 32'h0000_0001);
    hread(12'hF04, v); check(v == 32'h4000_0001, "R8 error kept", v, 32'h4000_0001);
    hwrite(12'hF04, 32'h4000_0002);
    hread(12'hF04, v); check(v == 32'h0000_0002, "R8 error cleared", v, 32'h0000_0002);

    check(expq.size() == 0, "R3/R4 all transfers seen", expq.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule